// File: doc/BRIEF.md
# Phase-Sampled Timer with External Clock Input

This block is an 8-bit up-counter for a small controller core. It runs on the fast oscillator clock. An instruction cycle is four oscillator periods long, and the block calls those periods phases Q1 to Q4. The counter can advance in one of two ways. With the internal source it advances once per instruction cycle. With the external source it follows edges on a pin. An optional power-of-two prescaler can sit in front of either source.

The external signal is never used as a clock. It is looked at only on the Q2 and Q4 edges, and the counter only changes on a Q4 edge. The block therefore counts external edges with a bounded delay. It drops pulses so narrow that no sample edge lands on them. When the external source is selected, the block raises a flag that forces the shared pin to act as an input.

A write to the counter does three things: it loads the value, clears the prescaler and holds off counting for two instruction cycles. The counter wraps from all-ones to zero and flags each wrap with a one-cycle pulse.

Top module: `tmr_phase_counter`

## Requirements
- R1: While reset is high and on the first clock after it is released, `count` is 0 and `ovf` is 0.
- R2: `pin_force_in` is 1 exactly when `src_ext` is 1, in the same cycle, whatever else is applied.
- R3: With `src_ext`=0 and `pre_on`=0, and outside the hold-off window, `count` rises by one every four clocks, and only on a Q4 edge.
- R4: With `src_ext`=0 and `pre_on`=1, `count` rises once every 2^(`pre_rate`+1) instruction cycles. The cycles are counted from the end of the hold-off window that follows a write.
- R5: A clock edge with `wr_en`=1 loads `wr_data` into `count`. The next two Q4 edges do not increment. Eight clocks after the write edge `count` still equals `wr_data`, and twelve clocks after it `count` equals `wr_data`+1 in internal mode without prescaler.
- R6: An increment from 8'hFF gives 8'h00, and `ovf` is high for exactly one clock while `count` is 0. A write never raises `ovf`.
- R7: With `src_ext`=1, `fall_edge`=0 and `pre_on`=0, each rising edge of `ext_pin` that is followed by at least two clocks high and two clocks low adds exactly one to `count`.
- R8: The first clock edge after reset release is a Q1 edge, and the phases then repeat Q1, Q2, Q3, Q4. Only Q2 and Q4 edges sample the source. A pin pulse that is high across a single Q3 edge only is not counted. A pulse high across that Q3 edge and the following Q4 edge is counted once.
- R9: In external mode without prescaler, `count` changes between 3 and 7 clocks after `ext_pin` rises, for every alignment of the rise to the phases.
- R10: With `fall_edge`=1, the pin is inverted before all other logic, so falling edges of `ext_pin` are the ones counted.
- R11: With `src_ext`=1 and `pre_on`=1, the counter advances once per 2^(`pre_rate`+1) rising edges of `ext_pin`, counted from the last write. Pin edges may come every second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period per phase |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External count input |
| src_ext | input | 1 | 1 selects the pin as source, 0 the instruction cycle |
| fall_edge | input | 1 | 1 counts falling pin edges instead of rising ones |
| pre_on | input | 1 | 1 places the prescaler in front of the counter |
| pre_rate | input | 3 | Prescale ratio selector n, ratio 2^(n+1) |
| wr_en | input | 1 | Load strobe for the counter |
| wr_data | input | 8 | Value loaded by `wr_en` |
| count | output | 8 | Current counter value |
| ovf | output | 1 | One-clock pulse on wrap to zero |
| pin_force_in | output | 1 | Forces the shared pin to be an input |

## Verification
The counter is driven in several ways: by the instruction cycle with and without a divider, and by the pin with slow square waves on either polarity. It is also driven by fast pin toggles through the divider, which check that the divider's symmetric output survives the two-per-cycle sampling. Single-clock pulses are placed on a Q3 edge, next to two-clock pulses at the same spot, which separates a true phase sampler from a plain edge detector. A pin rise is placed at each of the four phase offsets, which shows that the latency window is met at its short and long ends. Loads just below the wrap point, and a load of all-ones, separate a real wrap from a load.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_CNT_W   = 8;
    localparam int TMR_RATE_W  = 3;
    localparam int TMR_HOLDOFF = 2;

    // Four oscillator periods per instruction cycle
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    // Mode controls gathered for the datapath
    typedef struct packed {
        logic ext_src;
        logic fall_edge;
        logic pre_on;
    } tmr_mode_t;

    function automatic phase_e next_phase(phase_e p);
        logic [1:0] v;
        v = p;
        v = v + 2'd1;
        return phase_e'(v);
    endfunction

    function automatic logic is_sample_phase(phase_e p);
        return (p == PH_Q2) || (p == PH_Q4);
    endfunction

endpackage

// File: rtl/tmr_phase_gen.sv
module tmr_phase_gen
    import tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_Q1;
        end else begin
            phase <= next_phase(phase);
        end
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [RATE_W-1:0] rate,
    output logic              out_bit,
    output logic              carry
);

    localparam int PRE_W = 1 << RATE_W;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] mask;

    // Bits rate..0 take part in the division
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i <= int'(rate));
        end
    end

    assign out_bit = cnt[rate];
    assign carry   = step && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + PRE_W'(1);
        end
    end

    // R4
    pre_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/tmr_edge_sampler.sv
module tmr_edge_sampler
    import tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  phase_e phase,
    input  logic   src,
    output logic   inc_req
);

    logic smp;
    logic pend;
    logic rise;

    assign rise    = is_sample_phase(phase) && src && !smp;
    assign inc_req = (phase == PH_Q4) && pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp  <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (is_sample_phase(phase)) begin
                smp <= src;
            end
            if (flush) begin
                pend <= 1'b0;
            end else if (phase == PH_Q4) begin
                pend <= rise;
            end else if (phase == PH_Q2) begin
                pend <= pend | rise;
            end
        end
    end

    // R8
    sample_only_chk: assert property (@(posedge clk) disable iff (rst)
        !is_sample_phase(phase) |=> $stable(smp));

endmodule

// File: rtl/tmr_phase_counter.sv
module tmr_phase_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W   = TMR_CNT_W,
    parameter int RATE_W  = TMR_RATE_W,
    parameter int HOLDOFF = TMR_HOLDOFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin,
    input  logic              src_ext,
    input  logic              fall_edge,
    input  logic              pre_on,
    input  logic [RATE_W-1:0] pre_rate,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              pin_force_in
);

    localparam int HOLD_W = $clog2(HOLDOFF + 1);

    tmr_mode_t         mode;
    phase_e            phase;
    logic              pin_lvl;
    logic              pin_q;
    logic              pin_rise;
    logic [HOLD_W-1:0] hold;
    logic              held;
    logic              q4;
    logic              tick_int;
    logic              pre_step;
    logic              pre_out;
    logic              pre_carry;
    logic              samp_src;
    logic              samp_inc;
    logic              inc_ext;
    logic              inc_int;
    logic              inc;

    assign mode = '{ext_src: src_ext, fall_edge: fall_edge, pre_on: pre_on};

    tmr_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    // Polarity choice happens before any other stage
    assign pin_lvl  = ext_pin ^ mode.fall_edge;
    assign pin_rise = pin_lvl && !pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_lvl;
        end
    end

    assign held     = (hold != '0);
    assign q4       = (phase == PH_Q4);
    assign tick_int = q4 && !held;
    assign pre_step = mode.ext_src ? pin_rise : tick_int;

    tmr_prescaler #(.RATE_W(RATE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clr     (wr_en),
        .step    (pre_step),
        .rate    (pre_rate),
        .out_bit (pre_out),
        .carry   (pre_carry)
    );

    assign samp_src = mode.pre_on ? pre_out : pin_lvl;

    tmr_edge_sampler u_samp (
        .clk     (clk),
        .rst     (rst),
        .flush   (wr_en),
        .phase   (phase),
        .src     (samp_src),
        .inc_req (samp_inc)
    );

    assign inc_ext = samp_inc && !held;
    assign inc_int = tick_int && (!mode.pre_on || pre_carry);
    assign inc     = !wr_en && (mode.ext_src ? inc_ext : inc_int);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
            hold  <= '0;
        end else begin
            ovf <= inc && (count == '1);
            if (wr_en) begin
                count <= wr_data;
                hold  <= HOLD_W'(HOLDOFF);
            end else begin
                if (inc) begin
                    count <= count + CNT_W'(1);
                end
                if (q4 && held) begin
                    hold <= hold - HOLD_W'(1);
                end
            end
        end
    end

    assign pin_force_in = mode.ext_src;

    // R6
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (count == '0));

    // R6
    ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);

    // R5
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (count == $past(wr_data)));

    // R3
    q4_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && (count != $past(count))) |-> ($past(phase) == PH_Q4));

endmodule

// File: tb/test_tmr_phase_counter.sv
module test_tmr_phase_counter;

    localparam int CLK_NS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin = 1'b0;
    logic       src_ext = 1'b0;
    logic       fall_edge = 1'b0;
    logic       pre_on = 1'b0;
    logic [2:0] pre_rate = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count;
    logic       ovf;
    logic       pin_force_in;

    int tests = 0;
    int fails = 0;
    int ecnt = 0;
    int ovf_pulses = 0;
    bit ovf_prev = 1'b0;
    bit done = 1'b0;

    // kinds: 0 count, 1 ovf level, 2 pin_force_in, 3 ovf pulse total
    typedef struct {
        string req;
        int    kind;
        int    val;
    } exp_t;

    exp_t sbq[$];

    always #(CLK_NS / 2) clk = ~clk;

    tmr_phase_counter i_tmr_phase_counter (
        .clk          (clk),
        .rst          (rst),
        .ext_pin      (ext_pin),
        .src_ext      (src_ext),
        .fall_edge    (fall_edge),
        .pre_on       (pre_on),
        .pre_rate     (pre_rate),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .count        (count),
        .ovf          (ovf),
        .pin_force_in (pin_force_in)
    );

    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    task automatic check(string req, int act, int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: pops expectations between clock edges
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_NS / 4);
            while (sbq.size() > 0) begin
                exp_t e;
                int act;
                e = sbq.pop_front();
                case (e.kind)
                    0:       act = int'(count);
                    1:       act = int'(ovf);
                    2:       act = int'(pin_force_in);
                    default: act = ovf_pulses;
                endcase
                check(e.req, act, e.val);
            end
        end
    end

    // R6 pulse width watch
    always @(negedge clk) begin
        if (!rst) begin
            if (ovf) ovf_pulses++;
            if (ovf && ovf_prev) check("R6 ovf width", 2, 1);
            ovf_prev = ovf;
        end
    end

    task automatic expect_val(string req, int kind, int val);
        exp_t e;
        e.req = req;
        e.kind = kind;
        e.val = val;
        sbq.push_back(e);
        while (sbq.size() > 0) #1;
    endtask

    task automatic clocks(int n);
        repeat (n) @(negedge clk);
    endtask

    // Returns just after the write edge's negedge: 0 edges after the write
    task automatic write(logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Next clock edge will carry phase index ph (0 = Q1)
    task automatic align(int ph);
        @(negedge clk);
        while ((ecnt % 4) != ph) @(negedge clk);
    endtask

    task automatic pulses(int n, int hi, int lo);
        for (int i = 0; i < n; i++) begin
            ext_pin = ~fall_edge;
            clocks(hi);
            ext_pin = fall_edge;
            clocks(lo);
        end
    endtask

    initial begin
        clocks(5);
        expect_val("R1 count in reset", 0, 0);
        expect_val("R1 ovf in reset", 1, 0);
        rst = 1'b0;
        clocks(1);
        expect_val("R1 count after reset", 0, 0);
        expect_val("R1 ovf after reset", 1, 0);

        expect_val("R2 force off", 2, 0);
        src_ext = 1'b1;
        expect_val("R2 force on", 2, 1);
        src_ext = 1'b0;
        expect_val("R2 force off again", 2, 0);

        // R5 / R3 internal, no prescaler
        write(8'h40);
        clocks(8);
        expect_val("R5 held after write", 0, 8'h40);
        clocks(4);
        expect_val("R5 first step after hold", 0, 8'h41);
        clocks(16);
        expect_val("R3 one per instruction cycle", 0, 8'h45);

        // R6 wrap
        write(8'hFE);
        clocks(12);
        expect_val("R6 before wrap", 0, 8'hFF);
        clocks(4);
        expect_val("R6 wrapped", 0, 8'h00);
        expect_val("R6 one pulse", 3, 1);
        write(8'hFF);
        clocks(8);
        expect_val("R6 write of FF", 0, 8'hFF);
        expect_val("R6 no pulse on write", 3, 1);

        // R4 internal prescaler
        pre_on = 1'b1;
        pre_rate = 3'd1;
        write(8'h10);
        clocks(40);
        expect_val("R4 divide by 4", 0, 8'h12);
        pre_rate = 3'd0;
        write(8'h10);
        clocks(32);
        expect_val("R4 divide by 2", 0, 8'h13);

        // R7 external rising edges
        pre_on = 1'b0;
        src_ext = 1'b1;
        ext_pin = 1'b0;
        clocks(2);
        write(8'h20);
        clocks(12);
        pulses(5, 4, 4);
        clocks(8);
        expect_val("R7 five slow pulses", 0, 8'h25);

        // R10 falling edges
        fall_edge = 1'b1;
        ext_pin = 1'b1;
        clocks(2);
        write(8'h30);
        clocks(12);
        pulses(3, 3, 3);
        clocks(8);
        expect_val("R10 three falling edges", 0, 8'h33);
        ext_pin = 1'b0;
        clocks(10);
        expect_val("R10 lone falling edge counts", 0, 8'h34);
        ext_pin = 1'b1;
        clocks(10);
        expect_val("R10 rising edge ignored", 0, 8'h34);

        // R8 narrow pulses
        fall_edge = 1'b0;
        ext_pin = 1'b0;
        clocks(2);
        write(8'h50);
        clocks(12);
        align(2);
        ext_pin = 1'b1;
        @(negedge clk);
        ext_pin = 1'b0;
        clocks(10);
        expect_val("R8 Q3-only pulse dropped", 0, 8'h50);
        align(2);
        ext_pin = 1'b1;
        clocks(2);
        ext_pin = 1'b0;
        clocks(10);
        expect_val("R8 Q3+Q4 pulse counted", 0, 8'h51);

        // R9 latency at every phase offset
        for (int ph = 0; ph < 4; ph++) begin
            int n;
            logic [7:0] v;
            ext_pin = 1'b0;
            clocks(8);
            align(ph);
            v = count;
            ext_pin = 1'b1;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (count == v && n < 20);
            check("R9 latency not below 3", int'(n >= 3), 1);
            check("R9 latency not above 7", int'(n <= 7), 1);
            clocks(6);
        end
        ext_pin = 1'b0;
        clocks(8);

        // R11 external prescaler
        pre_on = 1'b1;
        pre_rate = 3'd0;
        write(8'h60);
        clocks(12);
        pulses(8, 1, 1);
        clocks(10);
        expect_val("R11 divide by 2", 0, 8'h64);
        pre_rate = 3'd2;
        write(8'h60);
        clocks(12);
        pulses(16, 1, 1);
        clocks(10);
        expect_val("R11 divide by 8", 0, 8'h62);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule